// File: doc/BRIEF.md
# Rotation-Aligned Burst Clock-Enable Prescaler

This block produces the clock-enable for one processing core in a multi-core device. In that device the cores take turns at a shared memory in a fixed round-robin, one slot per system cycle. The block watches the round-robin slot counter. It lets the core run for one complete rotation, then holds the enable low for a programmed number of whole rotations, and repeats. The clock itself is never divided or stretched: every delivered edge has the system period, and a suppressed core simply sees no edges. Its state is held and its memory-side signals stay quiet.

Software-side logic presents an 8-bit skip count together with a one-cycle load strobe. The count is adopted only at a rotation boundary. Bursts therefore always start at slot 0 and end at the last slot, and the slot timing seen by every other core never moves. The registered enable can drive a latch-based gating cell directly, and a sleep flag reports the suppressed cycles.

Top module: `burst_clk_enable`

## Requirements
- R1: While reset is high and in the first cycle after it, core_en is 1 and core_sleep is 0, and the adopted skip count is 0.
- R2: With an adopted skip count of 0, core_en stays 1 on every cycle.
- R3: With an adopted skip count N > 0, core_en is 1 for one whole rotation and then 0 for N whole rotations, and this pattern repeats. The slot counter slot_idx runs 0, 1, …, CORES-1 and wraps to 0, advancing by one each cycle. core_en only changes between a cycle showing slot CORES-1 and the next cycle, which shows slot 0.
- R4: Every enabled rotation covers all CORES slots, from slot 0 through slot CORES-1, so the core's own memory slot always lies inside an enabled rotation.
- R5: A skip count loaded with skip_load=1 is not adopted in the middle of a rotation. The rest of the current rotation keeps its enable value, and the new count is adopted at the next boundary.
- R6: If several loads arrive before a boundary, the last one is adopted.
- R7: A load presented in the cycle that shows slot CORES-1 is adopted at the boundary that follows it immediately.
- R8: An idle stretch that is already under way completes the length it started with. A newly adopted count governs the idle stretches that follow the next burst.
- R9: core_sleep equals the inverse of core_en on every cycle.
- R10: The largest count, 255, gives one enabled rotation followed by exactly 255 idle rotations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_idx | input | $clog2(CORES) | Hub round-robin slot, 0 to CORES-1, steps by one per cycle |
| skip_val | input | 8 | Number of idle rotations after each burst |
| skip_load | input | 1 | One-cycle strobe that captures skip_val |
| core_en | output | 1 | Registered clock-enable for the core |
| core_sleep | output | 1 | High on the cycles where core_en is low |

## Verification
The properties assume that the hub slot counter advances by exactly one per cycle and wraps from CORES-1 to 0. One property checks this assumption at the input. The bench models the hub counter as a free-running counter that keeps turning through reset, so the assumption holds from the first cycle. Reset is held for several cycles so that the past-value checks see settled registers. Loads are placed deliberately in the middle of a burst rotation, in an idle rotation and in the last slot, which exercises each adoption path.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int unsigned DEF_CORES = 16;
    localparam int unsigned SKIP_W    = 8;

    typedef logic [SKIP_W-1:0] skip_t;

    // Rotation-level phase of the core
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_REST = 1'b1
    } phase_e;

    // Adopted and pending skip counts
    typedef struct packed {
        skip_t cur;
        skip_t pend;
        logic  pend_vld;
    } shadow_t;

    // Sequencer state: phase plus idle rotations still to serve
    typedef struct packed {
        phase_e phase;
        skip_t  left;
    } seq_t;

    // Advance the sequencer by one rotation boundary using count n
    function automatic seq_t seq_step(seq_t s, skip_t n);
        seq_t r;
        r = s;
        if (s.phase == PH_RUN) begin
            if (n != '0) begin
                r.phase = PH_REST;
                r.left  = n;
            end
        end else if (s.left == skip_t'(1)) begin
            r.phase = PH_RUN;
            r.left  = '0;
        end else begin
            r.left = s.left - skip_t'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/bce_skip_shadow.sv
module bce_skip_shadow
    import bce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  at_edge,
    input  logic  load,
    input  skip_t load_val,
    output skip_t eff_n,
    output skip_t active_n,
    output logic  pend_vld
);

    shadow_t sh;

    // Count that would be adopted at the boundary closing this cycle
    always_comb begin
        if (load)
            eff_n = load_val;
        else if (sh.pend_vld)
            eff_n = sh.pend;
        else
            eff_n = sh.cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (at_edge) begin
            sh.cur      <= eff_n;
            sh.pend_vld <= 1'b0;
        end else if (load) begin
            sh.pend     <= load_val;
            sh.pend_vld <= 1'b1;
        end
    end

    assign active_n = sh.cur;
    assign pend_vld = sh.pend_vld;

    // R5: the adopted count moves only across a rotation boundary
    a_r5_adopt_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !at_edge |=> $stable(sh.cur));

endmodule

// File: rtl/bce_rotation_seq.sv
module bce_rotation_seq
    import bce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  at_edge,
    input  skip_t n_eff,
    output logic  run_next
);

    seq_t st;
    seq_t nxt;

    always_comb begin
        nxt = at_edge ? seq_step(st, n_eff) : st;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_RUN;
            st.left  <= '0;
        end else begin
            st <= nxt;
        end
    end

    assign run_next = (nxt.phase == PH_RUN);

    // R8: an idle phase always has rotations left to serve
    a_r8_rest_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_REST) |-> (st.left != '0));

    // R3: the phase changes only across a rotation boundary
    a_r3_phase_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !at_edge |=> $stable(st.phase));

endmodule

// File: rtl/bce_enable_reg.sv
module bce_enable_reg (
    input  logic clk,
    input  logic rst,
    input  logic run_next,
    output logic en_q,
    output logic sleep_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b1;
            sleep_q <= 1'b0;
        end else begin
            en_q    <= run_next;
            sleep_q <= !run_next;
        end
    end

    // R9: the sleep flag mirrors the enable
    a_r9_sleep_complement: assert property (@(posedge clk) disable iff (rst)
        sleep_q != en_q);

endmodule

// File: rtl/burst_clk_enable.sv
module burst_clk_enable
    import bce_pkg::*;
#(
    parameter  int unsigned CORES  = DEF_CORES,
    localparam int unsigned SLOT_W = $clog2(CORES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [SKIP_W-1:0] skip_val,
    input  logic              skip_load,
    output logic              core_en,
    output logic              core_sleep
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CORES - 1);

    logic  at_edge;
    skip_t n_eff;
    skip_t n_active;
    logic  n_pend;
    logic  run_next;

    // The cycle showing the final slot closes a rotation
    assign at_edge = (slot_idx == LAST_SLOT);

    bce_skip_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .at_edge  (at_edge),
        .load     (skip_load),
        .load_val (skip_val),
        .eff_n    (n_eff),
        .active_n (n_active),
        .pend_vld (n_pend)
    );

    bce_rotation_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .at_edge  (at_edge),
        .n_eff    (n_eff),
        .run_next (run_next)
    );

    bce_enable_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .run_next (run_next),
        .en_q     (core_en),
        .sleep_q  (core_sleep)
    );

    // R3: hub slot input steps by one and wraps (input assumption)
    a_r3_slot_steps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot_idx == (($past(slot_idx) == LAST_SLOT) ? '0
                                : $past(slot_idx) + 1'b1)));

    // R3, R4: the enable toggles only between the last slot and slot 0
    a_r3_en_moves_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(core_en) |-> ($past(slot_idx) == LAST_SLOT));

    // R2: with zero adopted and nothing pending the core stays enabled
    a_r2_zero_keeps_on: assert property (@(posedge clk) disable iff (rst)
        (core_en && n_active == '0 && !n_pend && !skip_load) |=> core_en);

endmodule

// File: tb/sim_burst_clk_enable.sv
module sim_burst_clk_enable;

    localparam int CLK_PERIOD = 10;
    localparam int CORES      = 16;
    localparam int LAST       = CORES - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] slot = '0;
    logic [7:0] skip_val = '0;
    logic       skip_load = 1'b0;
    logic       core_en;
    logic       core_sleep;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_clk_enable #(.CORES(CORES)) u0 (
        .clk        (clk),
        .rst        (rst),
        .slot_idx   (slot),
        .skip_val   (skip_val),
        .skip_load  (skip_load),
        .core_en    (core_en),
        .core_sleep (core_sleep)
    );

    // Advance one cycle: hub slot steps, strobe clears; outputs then settled
    task automatic tick();
        @(posedge clk);
        #2;
        slot      = (int'(slot) == LAST) ? 4'd0 : slot + 4'd1;
        skip_load = 1'b0;
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b slot=%0d", req, act, exp, slot);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
    endtask

    task automatic advance_to(input int s);
        while (int'(slot) != s) tick();
    endtask

    task automatic load(input int n);
        skip_val  = 8'(n);
        skip_load = 1'b1;
    endtask

    // From slot 0: rotation r is enabled iff r mod (n+1) == n
    task automatic check_rotations(input int n, input int rots, input string req);
        for (int r = 0; r < rots; r++) begin
            for (int s = 0; s < CORES; s++) begin
                logic exp;
                exp = ((r % (n + 1)) == n);
                chk(core_en, exp, req);
                chk(core_sleep, !exp, "R9");
                tick();
            end
        end
    endtask

    task automatic finish_burst(input string req);
        while (int'(slot) != 0) begin
            chk(core_en, 1'b1, req);
            tick();
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(core_en, 1'b1, "R1");
        chk(core_sleep, 1'b0, "R1");
        tick();
        chk(core_en, 1'b1, "R1");
    endtask

    task automatic t_zero();
        do_reset();
        advance_to(3);
        load(0);
        tick();
        repeat (3 * CORES) begin
            chk(core_en, 1'b1, "R2");
            chk(core_sleep, 1'b0, "R9");
            tick();
        end
    endtask

    task automatic t_pattern(input int n, input string req);
        do_reset();
        advance_to(5);
        load(n);
        tick();
        finish_burst("R5");
        check_rotations(n, (n == 255) ? 257 : 2 * (n + 1) + 1, req);
    endtask

    task automatic t_last_wins();
        do_reset();
        advance_to(3);
        load(5);
        tick();
        advance_to(7);
        load(1);
        tick();
        finish_burst("R5");
        check_rotations(1, 5, "R6");
    endtask

    task automatic t_last_slot_load();
        do_reset();
        advance_to(LAST);
        load(2);
        tick();
        check_rotations(2, 7, "R7");
    endtask

    // Idle underway with count 2, switch to 0 during first idle rotation
    task automatic t_idle_finish();
        do_reset();
        advance_to(5);
        load(2);
        tick();
        finish_burst("R5");
        for (int r = 0; r < 6; r++) begin
            for (int s = 0; s < CORES; s++) begin
                logic exp;
                exp = (r >= 2);
                chk(core_en, exp, "R8");
                chk(core_sleep, !exp, "R9");
                if (r == 0 && s == 4) load(0);
                else if (r != 0 || s != 5) skip_load = 1'b0;
                tick();
            end
        end
    endtask

    initial begin
        tick();
        t_reset();
        t_zero();
        t_pattern(1, "R3");
        t_pattern(3, "R4");
        t_pattern(255, "R10");
        t_last_wins();
        t_last_slot_load();
        t_idle_finish();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule